// File: doc/BRIEF.md
# Write-Through Invalidating Snoop Controller

This block tracks per-line coherence for a small direct-mapped cache that uses write-through and shares a snooping bus with other caches. Each line is either valid (its word matches memory) or invalid (not present). A processor read to a resident line is answered from the local word with no bus traffic. A read that misses wins the bus and fetches the word, and the line becomes valid. Every processor write goes to the bus so that memory stays current. The line's state never changes because of a write, and a write to a line that is not present does not allocate it.

The snoop side watches all bus traffic. When another cache writes an address whose tag is held valid here, that line drops to invalid, and the next local read fetches the fresh value. Bus reads, writes whose tag does not match, and this cache's own transactions (recognised by the source identifier on the snoop port) leave the line untouched.

The bus side uses a request/grant handshake. The controller raises a request, waits for the grant, then drives one command until the bus acknowledges it. The processor is stalled from the moment such a request is accepted until the transaction completes.

Top module: `wt_snoop_ctrl`

## Requirements
- R1: After reset all lines are invalid and cpu_stall, bus_req, bus_cmd_valid and cpu_done are low. The first read of any address therefore causes a bus read.
- R2: A read whose line is invalid, or whose stored tag differs, issues one bus read of cpu_addr. In the cycle after bus_ack, cpu_done pulses with cpu_rdata equal to the bus_rdata returned, and the line becomes valid with the new tag.
- R3: A read whose line is valid with a matching tag pulses cpu_done in the next cycle with the stored word. It raises no bus request and does not stall.
- R4: Every accepted write issues exactly one bus write (bus_cmd_we=1) carrying cpu_addr and cpu_wdata. In the grant cycle, a resident matching line has its word replaced and stays valid. A non-resident line stays absent.
- R5: A snooped write (snp_valid=1, snp_we=1) from a source other than SELF_ID, whose address tag matches a valid line at its index, makes that line invalid. The next read of that address misses.
- R6: A snooped read (snp_we=0), a snooped write carrying snp_id equal to SELF_ID, and a snooped write whose tag differs from the stored tag all leave the line valid.
- R7: bus_req stays high until bus_gnt is seen, and bus_cmd_valid rises only in the cycle after a grant. The command (valid, we, address) stays stable until bus_ack. With a grant latency of L cycles, bus_req is high for L+1 cycles.
- R8: cpu_stall is high from the cycle after a miss read or a write is accepted until cpu_done. Requests presented while cpu_stall is high are ignored and produce no bus transaction.
- R9: The index is the low IDX_W bits of the address and the tag is the remaining high bits. A read of a different tag at an occupied index replaces the line, so the old address misses afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, taken when cpu_stall is low |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_stall | output | 1 | Controller busy with a bus transaction |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Read result, valid with cpu_done |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| bus_cmd_valid | output | 1 | Command phase active |
| bus_cmd_we | output | 1 | Command is a write |
| bus_addr | output | ADDR_W | Command address |
| bus_wdata | output | DATA_W | Command write data |
| bus_ack | input | 1 | Command completes, read data present |
| bus_rdata | input | DATA_W | Read data from memory |
| snp_valid | input | 1 | A transaction is visible on the bus |
| snp_we | input | 1 | Observed transaction is a write |
| snp_addr | input | ADDR_W | Observed address |
| snp_id | input | ID_W | Source identifier of the observed transaction |

## Verification
The assertions assume that bus_ack arrives only while bus_cmd_valid is high, that bus_gnt arrives only while bus_req is high, and that a foreign snooped write never lands in the same cycle as this cache's own acknowledged fill, since a shared bus carries one transaction at a time. The bench's bus model grants only pending requests after a chosen latency and acknowledges only a live command. Snooped transactions are injected only while the controller is idle, so they never coincide with a fill. Foreign writes also update the bench memory, which exposes any stale hit.

// File: rtl/wtsc_pkg.sv
package wtsc_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ARB  = 2'd1,
        PH_XFER = 2'd2
    } phase_e;
endpackage

// File: rtl/wtsc_line_store.sv
module wtsc_line_store #(
    parameter int IDX_W  = 2,
    parameter int TAG_W  = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  lk_idx,
    output logic              lk_valid,
    output logic [TAG_W-1:0]  lk_tag,
    output logic [DATA_W-1:0] lk_data,
    input  logic [IDX_W-1:0]  sp_idx,
    output logic              sp_valid,
    output logic [TAG_W-1:0]  sp_tag,
    input  logic              fill_en,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [DATA_W-1:0] fill_data,
    input  logic              upd_en,
    input  logic [IDX_W-1:0]  upd_idx,
    input  logic [DATA_W-1:0] upd_data,
    input  logic              inv_en,
    input  logic [IDX_W-1:0]  inv_idx
);
    localparam int LINES = 1 << IDX_W;

    typedef struct packed {
        logic [LINES-1:0]             vld;
        logic [LINES-1:0][TAG_W-1:0]  tag;
        logic [LINES-1:0][DATA_W-1:0] dat;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (upd_en) begin
            st_d.dat[upd_idx] = upd_data;
        end
        if (fill_en) begin
            st_d.vld[fill_idx] = 1'b1;
            st_d.tag[fill_idx] = fill_tag;
            st_d.dat[fill_idx] = fill_data;
        end
        if (inv_en) begin
            st_d.vld[inv_idx] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lk_valid = st_q.vld[lk_idx];
    assign lk_tag   = st_q.tag[lk_idx];
    assign lk_data  = st_q.dat[lk_idx];
    assign sp_valid = st_q.vld[sp_idx];
    assign sp_tag   = st_q.tag[sp_idx];

    // R2
    fill_sets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en && !(inv_en && inv_idx == fill_idx) |=> st_q.vld[$past(fill_idx)]);

    // R5
    inv_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_en && !fill_en |=> !st_q.vld[$past(inv_idx)]);

    // R4
    upd_keeps_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en && !fill_en && !inv_en |=> st_q.vld[$past(upd_idx)] == $past(st_q.vld[upd_idx]));
endmodule

// File: rtl/wtsc_snoop_hit.sv
module wtsc_snoop_hit #(
    parameter int TAG_W   = 4,
    parameter int ID_W    = 2,
    parameter int SELF_ID = 1
) (
    input  logic             snp_valid,
    input  logic             snp_we,
    input  logic [ID_W-1:0]  snp_id,
    input  logic [TAG_W-1:0] snp_tag,
    input  logic             line_valid,
    input  logic [TAG_W-1:0] line_tag,
    output logic             kill
);
    localparam logic [ID_W-1:0] SELF = ID_W'(SELF_ID);

    logic foreign_wr;
    assign foreign_wr = snp_valid && snp_we && (snp_id != SELF);
    assign kill       = foreign_wr && line_valid && (line_tag == snp_tag);
endmodule

// File: rtl/wt_snoop_ctrl.sv
module wt_snoop_ctrl
    import wtsc_pkg::*;
#(
    parameter int ADDR_W  = 6,
    parameter int IDX_W   = 2,
    parameter int DATA_W  = 16,
    parameter int ID_W    = 2,
    parameter int SELF_ID = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_stall,
    output logic              cpu_done,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              bus_cmd_valid,
    output logic              bus_cmd_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              snp_valid,
    input  logic              snp_we,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic [ID_W-1:0]   snp_id
);
    localparam int TAG_W = ADDR_W - IDX_W;

    typedef struct packed {
        phase_e            phase;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              done;
        logic [DATA_W-1:0] rdata;
    } ctl_t;

    ctl_t c_d, c_q;

    logic              idle;
    logic [ADDR_W-1:0] lk_addr;
    logic              lk_valid, lk_hit;
    logic [TAG_W-1:0]  lk_tag;
    logic [DATA_W-1:0] lk_data;
    logic              sp_valid, kill;
    logic [TAG_W-1:0]  sp_tag;
    logic              fill_en, upd_en, accept;

    assign idle    = (c_q.phase == PH_IDLE);
    assign lk_addr = idle ? cpu_addr : c_q.addr;
    assign lk_hit  = lk_valid && (lk_tag == lk_addr[ADDR_W-1:IDX_W]);
    assign accept  = cpu_req && idle;

    wtsc_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_idx    (lk_addr[IDX_W-1:0]),
        .lk_valid  (lk_valid),
        .lk_tag    (lk_tag),
        .lk_data   (lk_data),
        .sp_idx    (snp_addr[IDX_W-1:0]),
        .sp_valid  (sp_valid),
        .sp_tag    (sp_tag),
        .fill_en   (fill_en),
        .fill_idx  (c_q.addr[IDX_W-1:0]),
        .fill_tag  (c_q.addr[ADDR_W-1:IDX_W]),
        .fill_data (bus_rdata),
        .upd_en    (upd_en),
        .upd_idx   (c_q.addr[IDX_W-1:0]),
        .upd_data  (c_q.wdata),
        .inv_en    (kill),
        .inv_idx   (snp_addr[IDX_W-1:0])
    );

    wtsc_snoop_hit #(.TAG_W(TAG_W), .ID_W(ID_W), .SELF_ID(SELF_ID)) u_snoop (
        .snp_valid  (snp_valid),
        .snp_we     (snp_we),
        .snp_id     (snp_id),
        .snp_tag    (snp_addr[ADDR_W-1:IDX_W]),
        .line_valid (sp_valid),
        .line_tag   (sp_tag),
        .kill       (kill)
    );

    always_comb begin
        c_d      = c_q;
        c_d.done = 1'b0;
        fill_en  = 1'b0;
        upd_en   = 1'b0;
        case (c_q.phase)
            PH_IDLE: begin
                if (accept) begin
                    if (!cpu_we && lk_hit) begin
                        c_d.done  = 1'b1;
                        c_d.rdata = lk_data;
                    end else begin
                        c_d.phase = PH_ARB;
                        c_d.we    = cpu_we;
                        c_d.addr  = cpu_addr;
                        c_d.wdata = cpu_wdata;
                    end
                end
            end
            PH_ARB: begin
                if (bus_gnt) begin
                    c_d.phase = PH_XFER;
                    upd_en    = c_q.we && lk_hit;
                end
            end
            PH_XFER: begin
                if (bus_ack) begin
                    c_d.phase = PH_IDLE;
                    c_d.done  = 1'b1;
                    if (!c_q.we) begin
                        fill_en   = 1'b1;
                        c_d.rdata = bus_rdata;
                    end
                end
            end
            default: c_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign cpu_stall     = !idle;
    assign cpu_done      = c_q.done;
    assign cpu_rdata     = c_q.rdata;
    assign bus_req       = (c_q.phase == PH_ARB);
    assign bus_cmd_valid = (c_q.phase == PH_XFER);
    assign bus_cmd_we    = c_q.we;
    assign bus_addr      = c_q.addr;
    assign bus_wdata     = c_q.wdata;

    // R3
    rd_hit_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept && !cpu_we && lk_hit |=> cpu_done && !cpu_stall && !bus_req);

    // R7
    cmd_after_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_cmd_valid) |-> $past(bus_gnt));

    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_gnt |=> bus_req);

    // R7
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cmd_valid && !bus_ack |=> bus_cmd_valid && $stable(bus_addr) && $stable(bus_cmd_we));

    // R2
    ack_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cmd_valid && bus_ack |=> cpu_done && !cpu_stall);
endmodule

// File: tb/tb_wt_snoop_ctrl.sv
module tb_wt_snoop_ctrl;
    localparam int AW = 6, IW = 2, DW = 16, IDW = 2, SELF = 1, OTHER = 2;
    localparam int NL = 1 << IW, NA = 1 << AW;

    logic clk = 0, rst_n = 0;
    logic cpu_req = 0, cpu_we = 0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic cpu_stall, cpu_done, bus_req, bus_cmd_valid, bus_cmd_we;
    logic [DW-1:0] cpu_rdata, bus_wdata;
    logic [AW-1:0] bus_addr;
    logic bus_gnt = 0, bus_ack = 0;
    logic [DW-1:0] bus_rdata = '0;
    logic snp_valid = 0, snp_we = 0;
    logic [AW-1:0] snp_addr = '0;
    logic [IDW-1:0] snp_id = '0;

    int total = 0, bad = 0, cycles = 0;
    int txn_cnt = 0, gnt_lat = 0, req_run = 0;
    logic [AW-1:0] last_wa;
    logic [DW-1:0] last_wd;
    logic [DW-1:0] mem [NA];
    logic m_vld [NL];
    logic [AW-IW-1:0] m_tag [NL];
    logic [15:0] lfsr = 16'hACE1;

    always #2 clk = ~clk;

    wt_snoop_ctrl #(.ADDR_W(AW), .IDX_W(IW), .DATA_W(DW), .ID_W(IDW), .SELF_ID(SELF)) dut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_stall(cpu_stall), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd_valid(bus_cmd_valid), .bus_cmd_we(bus_cmd_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .snp_valid(snp_valid), .snp_we(snp_we), .snp_addr(snp_addr), .snp_id(snp_id));

    task automatic check(input bit ok, input string r, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", r, act, exp);
        end
    endtask

    // bus and memory model, acts at falling edges
    always @(negedge clk) begin
        if (bus_req) begin
            req_run++;
            bus_gnt = (req_run == gnt_lat + 1);
        end else begin
            bus_gnt = 0;
        end
        if (bus_cmd_valid && !bus_ack) begin
            check(req_run == gnt_lat + 1, "R7 request length", req_run, gnt_lat + 1);
            bus_ack = 1;
            bus_rdata = mem[bus_addr];
            if (bus_cmd_we) begin
                mem[bus_addr] = bus_wdata;
                last_wa = bus_addr;
                last_wd = bus_wdata;
            end
            txn_cnt++;
            req_run = 0;
        end else begin
            bus_ack = 0;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=%0d expected=<150000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic do_read(input logic [AW-1:0] a, input string lbl, input bit poke);
        int c0;
        bit exp_hit;
        exp_hit = m_vld[a[IW-1:0]] && (m_tag[a[IW-1:0]] == a[AW-1:IW]);
        @(negedge clk);
        c0 = txn_cnt;
        cpu_req = 1; cpu_we = 0; cpu_addr = a;
        @(negedge clk);
        cpu_req = 0;
        if (poke && !exp_hit) begin
            check(cpu_stall == 1, "R8 stall during miss", cpu_stall, 1);
            cpu_req = 1; cpu_we = 1; cpu_addr = a ^ 6'h1; cpu_wdata = 16'hDEAD;
            @(negedge clk);
            cpu_req = 0;
        end
        while (!cpu_done) @(negedge clk);
        check(cpu_rdata == mem[a], {lbl, " read data"}, cpu_rdata, mem[a]);
        check((txn_cnt - c0) == (exp_hit ? 0 : 1),
              exp_hit ? {lbl, " R3 hit no bus"} : {lbl, " R2 miss one bus read"},
              txn_cnt - c0, exp_hit ? 0 : 1);
        m_vld[a[IW-1:0]] = 1;
        m_tag[a[IW-1:0]] = a[AW-1:IW];
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        int c0;
        @(negedge clk);
        c0 = txn_cnt;
        cpu_req = 1; cpu_we = 1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_req = 0;
        while (!cpu_done) @(negedge clk);
        check((txn_cnt - c0) == 1, "R4 write count", txn_cnt - c0, 1);
        check(last_wa == a && last_wd == d, "R4 write addr/data", int'(last_wd), int'(d));
    endtask

    task automatic do_snoop(input logic [AW-1:0] a, input logic [IDW-1:0] id,
                            input bit we, input logic [DW-1:0] d);
        @(negedge clk);
        snp_valid = 1; snp_we = we; snp_addr = a; snp_id = id;
        if (we && id != SELF) begin
            mem[a] = d;
            if (m_vld[a[IW-1:0]] && m_tag[a[IW-1:0]] == a[AW-1:IW]) m_vld[a[IW-1:0]] = 0;
        end
        @(negedge clk);
        snp_valid = 0;
    endtask

    initial begin
        for (int i = 0; i < NA; i++) mem[i] = DW'(i * 37 + 5);
        for (int i = 0; i < NL; i++) begin m_vld[i] = 0; m_tag[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset outputs
        check(!cpu_stall && !bus_req && !bus_cmd_valid && !cpu_done, "R1 reset outputs",
              {cpu_stall, bus_req, bus_cmd_valid, cpu_done}, 0);
        for (int i = 0; i < NL; i++) do_read(AW'(i), "R1 first read", 0);
        for (int i = 0; i < NL; i++) do_read(AW'(i), "R3 reread", 0);
        // R9 conflicting tags at index 0
        do_read(6'd4, "R9 new tag", 0);
        do_read(6'd0, "R9 old tag back", 0);
        // R4 resident and non-resident writes
        gnt_lat = 2;
        do_write(6'd0, 16'h1234);
        do_read(6'd0, "R4 resident write then hit", 0);
        do_write(6'd8, 16'h4321);
        do_read(6'd8, "R4 nonresident stays absent", 0);
        // R5 foreign write invalidates
        do_snoop(6'd8, OTHER, 1, 16'h7777);
        do_read(6'd8, "R5 after foreign write", 0);
        // R6 ignored snoops
        do_snoop(6'd8, SELF, 1, 16'h0);
        do_snoop(6'd8, OTHER, 0, 16'h0);
        do_snoop(6'd12, OTHER, 1, 16'h5555);
        do_read(6'd8, "R6 line kept", 0);
        // R8 request while stalled is ignored
        gnt_lat = 3;
        do_read(6'd21, "R8 poke", 1);
        do_read(6'd20, "R8 poked addr untouched", 0);
        // near-exhaustive mixed sweep
        for (int k = 0; k < 600; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            gnt_lat = int'(lfsr[9:8]);
            case (lfsr[11:10])
                2'd0, 2'd1: do_read(lfsr[5:0], "R2/R3 sweep", 0);
                2'd2:       do_write(lfsr[5:0], {lfsr[7:0], lfsr[15:8]});
                default:    do_snoop(lfsr[5:0], lfsr[6] ? IDW'(SELF) : IDW'(OTHER),
                                     lfsr[7], lfsr ^ 16'h0F0F);
            endcase
        end
        // every address once more, checking against the model
        for (int a = 0; a < NA; a++) do_read(AW'(a), "R5/R9 final sweep", 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule